// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block gives a taken or not-taken guess for a conditional branch while it is being fetched. It holds two component predictors. The first is a two-level local predictor: a per-PC history table, followed by a table of counters indexed by that history. The second is a global predictor: a counter table indexed by a shared register of recent branch outcomes. A per-PC chooser counter decides which component's guess is used.

A lookup is combinational from the fetch PC. Along with the guess, the block returns a snapshot of the histories and component guesses it used. The pipeline carries that snapshot with the branch. When the branch resolves, it is handed back together with the branch PC and the real outcome. All training happens at resolve and uses the snapshot indices. A misprediction also rebuilds the global history from the snapshot.

Top module: `tourney_bp`

## Requirements
- R1: After reset, every counter holds 01 and every history is zero. Until the first resolve, every lookup therefore returns a not-taken guess and an all-zero snapshot.
- R2: Every per-PC structure is indexed by PC bits [4:2]. PC bits outside that field have no effect on the guess or the snapshot.
- R3: The local component guess is the upper bit of the local counter selected by the 3-bit local history held for the PC.
- R4: The global component guess is the upper bit of the global counter selected by the 3-bit global history register.
- R5: When the upper bit of the PC's chooser counter is 1, the final guess is the global guess. Otherwise it is the local guess.
- R6: On resolve, the local counter at the snapshot's local history and the global counter at the snapshot's global history each step by one toward the outcome (up for taken, 1 = taken). They saturate at 00 and 11.
- R7: On resolve, the chooser counter of the branch PC changes only when exactly one component guessed right. It steps up when the global guess was right and down when the local guess was right, saturating at 00 and 11.
- R8: On resolve, the local history entry of the branch PC becomes the snapshot's local history shifted left by one, with the outcome in bit 0.
- R9: On resolve, if the final guess in the snapshot matches the outcome, the global history register shifts left with the outcome in bit 0. On a mismatch it is first restored from the snapshot's global history, then shifted the same way.
- R10: The snapshot is 9 bits. Bits [2:0] hold the local history used, [5:3] the global history, [6] the local guess, [7] the global guess, and [8] the final guess.
- R11: Lookups without a resolve leave all predictor state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| look_pc_i | input | 32 | Fetch PC to predict |
| pred_taken_o | output | 1 | Final taken guess |
| pred_snap_o | output | 9 | Snapshot of indices and guesses for this lookup |
| res_valid_i | input | 1 | A branch resolves this cycle |
| res_pc_i | input | 32 | PC of the resolving branch |
| res_taken_i | input | 1 | Actual outcome, 1 = taken |
| res_snap_i | input | 9 | Snapshot returned with the resolving branch |

## Verification
The bench drives lookups against a reference model and compares every snapshot field on each lookup. The branch mix includes always-taken, never-taken, alternating, history-correlated and pseudo-random branches, so counters saturate at both ends and the chooser moves both ways.

A second phase resolves each branch one cycle after the next lookup, so the snapshot handed back is older than the live history. A design that shifted the live global history on a mispredict, or that trained the counters at the current indices instead of the snapshot indices, diverges there. Further cases cover upper PC bits that must be ignored, idle lookups that must not disturb state, and a reset in the middle of the run that must clear all learned state. A chooser trained on agreement would drift toward one side and pick the wrong component on later lookups.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  localparam int unsigned CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_MIN  = '0;
  localparam ctr_t CTR_MAX  = '1;
  localparam ctr_t CTR_INIT = ctr_t'(1);

  function automatic ctr_t ctr_move(ctr_t c, logic up);
    if (up) return (c == CTR_MAX) ? c : c + ctr_t'(1);
    else    return (c == CTR_MIN) ? c : c - ctr_t'(1);
  endfunction
endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table
  import tbp_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr_t             rd_ctr_o,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_up_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  ctr_t ent [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    ctr_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    q <= CTR_INIT;
      else if (upd_en_i && upd_idx_i == IDX_W'(gi))   q <= ctr_move(q, upd_up_i);
    end
    assign ent[gi] = q;
  end

  assign rd_ctr_o = ent[rd_idx_i];
endmodule

// File: rtl/tbp_hist_table.sv
module tbp_hist_table #(
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned HIST_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [HIST_W-1:0] rd_hist_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [HIST_W-1:0] wr_hist_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] ent [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    logic [HIST_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   q <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(gi))    q <= wr_hist_i;
    end
    assign ent[gi] = q;
  end

  assign rd_hist_o = ent[rd_idx_i];
endmodule

// File: rtl/tbp_ghr.sv
module tbp_ghr #(
  parameter int unsigned GHR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_en_i,
  input  logic             restore_i,
  input  logic [GHR_W-1:0] snap_i,
  input  logic             taken_i,
  output logic [GHR_W-1:0] ghr_o
);
  logic [GHR_W-1:0] base;

  // mispredict: rebuild from the prediction-time copy
  assign base = restore_i ? snap_i : ghr_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ghr_o <= '0;
    else if (upd_en_i) ghr_o <= {base[GHR_W-2:0], taken_i};
  end
endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
  import tbp_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned IDX_LSB = 2,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned HIST_W  = 3,
  parameter int unsigned GHR_W   = 3,
  parameter int unsigned SNAP_W  = HIST_W + GHR_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   look_pc_i,
  output logic              pred_taken_o,
  output logic [SNAP_W-1:0] pred_snap_o,
  input  logic              res_valid_i,
  input  logic [PC_W-1:0]   res_pc_i,
  input  logic              res_taken_i,
  input  logic [SNAP_W-1:0] res_snap_i
);
  localparam int unsigned G_LSB  = HIST_W;
  localparam int unsigned LP_BIT = HIST_W + GHR_W;
  localparam int unsigned GP_BIT = LP_BIT + 1;
  localparam int unsigned FP_BIT = LP_BIT + 2;

  logic [IDX_W-1:0]  look_idx, res_idx;
  logic [HIST_W-1:0] look_lhist, res_lhist;
  logic [GHR_W-1:0]  ghr, res_ghr;
  ctr_t              lctr, gctr, sel_ctr;
  logic              lpred, gpred, fpred;
  logic              res_lp, res_gp, res_fp, mispred, disagree;

  assign look_idx = look_pc_i[IDX_LSB +: IDX_W];
  assign res_idx  = res_pc_i[IDX_LSB +: IDX_W];

  assign res_lhist = res_snap_i[HIST_W-1:0];
  assign res_ghr   = res_snap_i[G_LSB +: GHR_W];
  assign res_lp    = res_snap_i[LP_BIT];
  assign res_gp    = res_snap_i[GP_BIT];
  assign res_fp    = res_snap_i[FP_BIT];
  assign mispred   = res_fp ^ res_taken_i;
  assign disagree  = res_lp ^ res_gp;

  tbp_hist_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_lhist (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (look_idx),
    .rd_hist_o (look_lhist),
    .wr_en_i   (res_valid_i),
    .wr_idx_i  (res_idx),
    .wr_hist_i ({res_lhist[HIST_W-2:0], res_taken_i})
  );

  tbp_ctr_table #(.IDX_W(HIST_W)) u_lpht (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (look_lhist),
    .rd_ctr_o  (lctr),
    .upd_en_i  (res_valid_i),
    .upd_idx_i (res_lhist),
    .upd_up_i  (res_taken_i)
  );

  tbp_ghr #(.GHR_W(GHR_W)) u_ghr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_en_i  (res_valid_i),
    .restore_i (mispred),
    .snap_i    (res_ghr),
    .taken_i   (res_taken_i),
    .ghr_o     (ghr)
  );

  tbp_ctr_table #(.IDX_W(GHR_W)) u_gpht (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (ghr),
    .rd_ctr_o  (gctr),
    .upd_en_i  (res_valid_i),
    .upd_idx_i (res_ghr),
    .upd_up_i  (res_taken_i)
  );

  // chooser: up = trust global, trained only on disagreement
  tbp_ctr_table #(.IDX_W(IDX_W)) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (look_idx),
    .rd_ctr_o  (sel_ctr),
    .upd_en_i  (res_valid_i && disagree),
    .upd_idx_i (res_idx),
    .upd_up_i  (res_gp == res_taken_i)
  );

  assign lpred = lctr[CTR_W-1];
  assign gpred = gctr[CTR_W-1];
  assign fpred = sel_ctr[CTR_W-1] ? gpred : lpred;

  assign pred_taken_o = fpred;
  assign pred_snap_o  = {fpred, gpred, lpred, ghr, look_lhist};
endmodule

// File: rtl/tourney_bp_chk.sv
module tourney_bp_chk #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned IDX_LSB = 2,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned HIST_W  = 3,
  parameter int unsigned GHR_W   = 3,
  parameter int unsigned SNAP_W  = HIST_W + GHR_W + 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PC_W-1:0]   look_pc_i,
  input logic              pred_taken_o,
  input logic [SNAP_W-1:0] pred_snap_o,
  input logic              res_valid_i,
  input logic [PC_W-1:0]   res_pc_i,
  input logic              res_taken_i,
  input logic [SNAP_W-1:0] res_snap_i
);
  localparam int unsigned G_LSB  = HIST_W;
  localparam int unsigned LP_BIT = HIST_W + GHR_W;
  localparam int unsigned GP_BIT = LP_BIT + 1;
  localparam int unsigned FP_BIT = LP_BIT + 2;

  logic seen_res_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          seen_res_q <= 1'b0;
    else if (res_valid_i) seen_res_q <= 1'b1;
  end

  logic [GHR_W-1:0] cur_ghr;
  assign cur_ghr = pred_snap_o[G_LSB +: GHR_W];

  p_reset_state_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_res_q |-> (!pred_taken_o && pred_snap_o == '0));

  p_ghr_shift_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |=> cur_ghr[0] == $past(res_taken_i));

  p_ghr_restore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && (res_snap_i[FP_BIT] != res_taken_i))
    |=> cur_ghr[GHR_W-1:1] == $past(res_snap_i[G_LSB +: GHR_W-1]));

  p_ghr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> cur_ghr == $past(cur_ghr));

  p_lhist_shift_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(res_valid_i) && seen_res_q &&
     look_pc_i[IDX_LSB +: IDX_W] == $past(res_pc_i[IDX_LSB +: IDX_W]))
    |-> pred_snap_o[HIST_W-1:0] == {$past(res_snap_i[HIST_W-2:0]), $past(res_taken_i)});

  p_final_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_taken_o |-> (pred_snap_o[LP_BIT] || pred_snap_o[GP_BIT]));
endmodule

bind tourney_bp tourney_bp_chk #(
  .PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W),
  .HIST_W(HIST_W), .GHR_W(GHR_W), .SNAP_W(SNAP_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .look_pc_i    (look_pc_i),
  .pred_taken_o (pred_taken_o),
  .pred_snap_o  (pred_snap_o),
  .res_valid_i  (res_valid_i),
  .res_pc_i     (res_pc_i),
  .res_taken_i  (res_taken_i),
  .res_snap_i   (res_snap_i)
);

// File: tb/tourney_bp_tb_top.sv
module tourney_bp_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] look_pc_i = '0;
  logic        pred_taken_o;
  logic [8:0]  pred_snap_o;
  logic        res_valid_i = 1'b0;
  logic [31:0] res_pc_i = '0;
  logic        res_taken_i = 1'b0;
  logic [8:0]  res_snap_i = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  tourney_bp dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .look_pc_i(look_pc_i),
    .pred_taken_o(pred_taken_o), .pred_snap_o(pred_snap_o),
    .res_valid_i(res_valid_i), .res_pc_i(res_pc_i),
    .res_taken_i(res_taken_i), .res_snap_i(res_snap_i)
  );

  // reference model
  logic [2:0] m_bht [8];
  logic [1:0] m_pht [8];
  logic [1:0] m_gt  [8];
  logic [1:0] m_ch  [8];
  logic [2:0] m_ghr;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [1:0] sat(logic [1:0] c, logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  function automatic logic [8:0] m_snap(logic [31:0] pc);
    logic [2:0] lh = m_bht[pc[4:2]];
    logic lp = m_pht[lh][1];
    logic gp = m_gt[m_ghr][1];
    logic fp = m_ch[pc[4:2]][1] ? gp : lp;
    return {fp, gp, lp, m_ghr, lh};
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 8; i++) begin
      m_bht[i] = '0; m_pht[i] = 2'b01; m_gt[i] = 2'b01; m_ch[i] = 2'b01;
    end
    m_ghr = '0;
  endtask

  task automatic m_update(logic [31:0] pc, logic t, logic [8:0] s);
    m_pht[s[2:0]] = sat(m_pht[s[2:0]], t);
    m_gt[s[5:3]]  = sat(m_gt[s[5:3]], t);
    if (s[6] != s[7]) m_ch[pc[4:2]] = sat(m_ch[pc[4:2]], s[7] == t);
    m_bht[pc[4:2]] = {s[1:0], t};
    if (s[8] != t) m_ghr = {s[4:3], t};
    else           m_ghr = {m_ghr[1:0], t};
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_look(string ph, logic [31:0] pc);
    logic [8:0] e = m_snap(pc);
    check({ph, " R10 R8 local history field"}, 32'(pred_snap_o[2:0]), 32'(e[2:0]));
    check({ph, " R9 global history field"}, 32'(pred_snap_o[5:3]), 32'(e[5:3]));
    check({ph, " R3 R6 local guess"}, 32'(pred_snap_o[6]), 32'(e[6]));
    check({ph, " R4 R6 global guess"}, 32'(pred_snap_o[7]), 32'(e[7]));
    check({ph, " R5 R7 final guess"}, 32'(pred_taken_o), 32'(e[8]));
    check({ph, " R10 final bit in snapshot"}, 32'(pred_snap_o[8]), 32'(e[8]));
  endtask

  // one cycle: lookup pc_l, optionally resolve (pc_r, t, s)
  task automatic step(string ph, logic [31:0] pc_l, logic rv,
                      logic [31:0] pc_r, logic t, logic [8:0] s);
    @(negedge clk_i);
    look_pc_i = pc_l; res_valid_i = rv; res_pc_i = pc_r;
    res_taken_i = t; res_snap_i = s;
    #1;
    check_look(ph, pc_l);
    if (rv) m_update(pc_r, t, s);
  endtask

  function automatic logic outcome(logic [2:0] idx, int k);
    case (idx)
      3'd0: return 1'b1;
      3'd1: return 1'b0;
      3'd2: return k[0];
      3'd3: return m_ghr[0] ^ m_ghr[1];
      default: return lfsr[0] ^ lfsr[5];
    endcase
  endfunction

  function automatic logic [31:0] mk_pc(logic [2:0] idx, logic [15:0] hi);
    return {hi, 11'h040, idx, 2'b00};
  endfunction

  initial begin
    logic [31:0] pc, pc_prev;
    logic [8:0]  s, s_prev;
    logic        t;
    m_reset();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1: reset state across all indices and odd upper bits
    for (int i = 0; i < 8; i++) begin
      step("reset", mk_pc(3'(i), 16'(i * 16'h1357)), 1'b0, '0, 1'b0, '0);
      check("R1 reset guess", 32'(pred_taken_o), 32'd0);
      check("R1 reset snapshot", 32'(pred_snap_o), 32'd0);
    end

    // immediate resolve: snapshot matches live state
    for (int k = 0; k < 600; k++) begin
      logic [2:0] idx = 3'(k % 8) ^ 3'(k / 64);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pc = mk_pc(idx, lfsr);
      s = m_snap(pc);
      t = outcome(idx, k / 8);
      step("train R2", pc, 1'b1, pc, t, s);
    end

    // delayed resolve: stale snapshot forces restore on mispredict
    pc_prev = mk_pc(3'd0, 16'h0);
    s_prev = m_snap(pc_prev);
    for (int k = 0; k < 600; k++) begin
      logic [2:0] idx = 3'((k * 3) % 8);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pc = mk_pc(idx, lfsr);
      s = m_snap(pc);
      t = outcome(pc_prev[4:2], k / 8);
      step("pipelined", pc, 1'b1, pc_prev, t, s_prev);
      pc_prev = pc;
      s_prev = s;
    end

    // R11: lookups only, nothing changes
    for (int k = 0; k < 16; k++)
      step("idle R11", mk_pc(3'(k % 8), 16'hBEEF), 1'b0, '0, 1'b0, '0);

    // R2: upper PC bits ignored
    for (int i = 0; i < 8; i++) begin
      logic [8:0] a;
      step("alias R2", mk_pc(3'(i), 16'h0000), 1'b0, '0, 1'b0, '0);
      a = pred_snap_o;
      step("alias R2", {16'hFFFF, 11'h7FF, 3'(i), 2'b11}, 1'b0, '0, 1'b0, '0);
      check("R2 upper bits ignored", 32'(pred_snap_o), 32'(a));
    end

    // R1: reset mid-run clears learned state
    @(negedge clk_i) rst_ni = 1'b0;
    m_reset();
    @(negedge clk_i) rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) begin
      step("rereset R1", mk_pc(3'(i), 16'h55AA), 1'b0, '0, 1'b0, '0);
      check("R1 reset snapshot again", 32'(pred_snap_o), 32'd0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule